// File: doc/BRIEF.md
# AES3 Channel-Status Indicator Decoder

This block sits behind a bi-phase decoder on an AES3 / S/PDIF receive path. For every decoded sub-frame it receives a one-cycle strobe, along with the preamble kind, the channel-status (C) bit, the validity (V) bit and three health inputs: the parity result, a bi-phase violation flag and the PLL lock state. From these inputs it tracks the 192-frame channel-status block. It keeps the low sixteen channel-status bits of each channel. From the channel picked by a select input it derives five steady indicators: professional mode, non-audio content, copy permission, pre-emphasis (active low) and original/copy generation.

A block marker output marks a fixed window inside each block, timed from the block-start preamble. The indicators are only refreshed inside that window, so a consumer can treat them as settled once the marker has fallen. Two error outputs report link health. One is updated per sub-frame and includes the validity bit. The other is updated per frame and ignores validity.

Top module: `cs_indicator_top`

## Requirements
- R1: While `rstN` is low at a clock edge, all outputs take their idle values after that edge: `blockMark`, `proOut`, `nonAudioOut`, `copyOut`, `origOut`, `errAll` and `errNoVal` are 0, and `emphN` is 1.
- R2: Preamble codes are Z=0, X=1 and Y=2. A frame is one Z- or X-strobe followed by one Y-strobe. The frame that carries Z is frame 0. `blockMark` is 1 from the cycle after the strobe of frame 2's first sub-frame until the cycle after the strobe of frame 18's first sub-frame, which is 16 frames. It is 0 otherwise.
- R3: When `chanSel` is 0, the indicators take channel A (the Z/X sub-frame) bits. When `chanSel` is 1, they take channel B (the Y sub-frame) bits. `chanSel` is sampled at each refresh.
- R4: Channel-status bit n is the C bit of frame n. On every first-sub-frame strobe of frames 2 to 17, the indicators reload from the bits received so far in the current block. In that reload, `proOut` is bit 0, `nonAudioOut` is bit 1 and `copyOut` is bit 2.
- R5: When bit 0 is 0, `emphN` is 0 only if bits 3, 4 and 5 are 1, 0 and 0. Otherwise it is 1.
- R6: When bit 0 is 1, `emphN` is 0 only if bits 2, 3 and 4 are 1, 1 and 0. Otherwise it is 1.
- R7: Bit 15 is the L flag. The category group is inverted when bits 8..10 are 0,0,1 or 1,0,0, or when bits 8..11 are 0,1,1,1. `origOut` is the L flag, negated for an inverted group.
- R8: On every sub-frame strobe, `errAll` becomes V OR parity-fail OR bi-phase error OR lock lost. It holds between strobes.
- R9: On each Y strobe, `errNoVal` becomes parity-fail OR bi-phase error OR lock lost, taken over both sub-frames of the frame. V has no effect, and the flag holds at all other times.
- R10: While `pllLock` is 0, `blockMark` and the indicators hold their values, no channel-status bit is stored, and block sync is dropped.
- R11: Without sync, X frames do not advance the block. An X that would start frame 192 also drops sync. While sync is absent, `blockMark` goes to 0 at the next first-sub-frame strobe and the indicators stop refreshing. Only a Z restores sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| subStrobe | input | 1 | One-cycle sub-frame valid strobe |
| preamble | input | 2 | Preamble kind: 0=Z, 1=X, 2=Y |
| cBit | input | 1 | Channel-status bit of the sub-frame |
| vBit | input | 1 | Validity bit of the sub-frame |
| parityOk | input | 1 | 1 when the sub-frame parity checked good |
| bipErr | input | 1 | Bi-phase coding violation in the sub-frame |
| pllLock | input | 1 | Receive PLL locked |
| chanSel | input | 1 | Indicator channel: 0=A, 1=B |
| blockMark | output | 1 | Channel-status block marker |
| proOut | output | 1 | Professional-mode bit |
| nonAudioOut | output | 1 | Non-audio bit |
| copyOut | output | 1 | Copy bit |
| emphN | output | 1 | Low for 50/15 us pre-emphasis |
| origOut | output | 1 | High for an original stream |
| errAll | output | 1 | Error including validity, per sub-frame |
| errNoVal | output | 1 | Error excluding validity, per frame |

## Verification
Every output is a register loaded at the clock edge that samples a strobe. The marker, the indicators and both error flags are therefore due exactly one cycle after the strobe that causes them. The marker edges follow the first-sub-frame strobes of frames 2 and 18, and `errNoVal` follows only the Y strobe. The bench reference model advances on the same edge as the design, and all eight outputs are compared on each falling edge. A result that arrives a cycle early or late is therefore caught.

// File: rtl/csi_pkg.sv
package csi_pkg;
  localparam int IDX_W   = 8;
  localparam int CS_BITS = 16;
  localparam int CS_IW   = $clog2(CS_BITS);

  typedef enum logic [1:0] {
    PRE_Z = 2'd0,
    PRE_X = 2'd1,
    PRE_Y = 2'd2,
    PRE_NONE = 2'd3
  } preamble_e;

  // Strobes from the frame control to the datapath
  typedef struct packed {
    logic             strbA;
    logic             strbY;
    logic             capA;
    logic             capB;
    logic             refresh;
    logic [IDX_W-1:0] idx;
  } csi_ctl_t;
endpackage

// File: rtl/csi_ctrl.sv
module csi_ctrl
  import csi_pkg::*;
#(
  parameter int BLOCK_LEN   = 192,
  parameter int MARK_DELAY  = 2,
  parameter int MARK_FRAMES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       subStrobe,
  input  logic [1:0] preamble,
  input  logic       pllLock,
  output csi_ctl_t   ctl,
  output logic       blockMark
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_LEN - 1);
  localparam logic [IDX_W-1:0] WIN_LO   = IDX_W'(MARK_DELAY);
  localparam logic [IDX_W-1:0] WIN_HI   = IDX_W'(MARK_DELAY + MARK_FRAMES - 1);

  preamble_e        pre;
  logic [IDX_W-1:0] frameIdx, nextIdx;
  logic             synced, nextSync;
  logic             isA, isZ, isY, inWin;

  always_comb begin
    pre  = preamble_e'(preamble);
    isZ  = (pre == PRE_Z);
    isA  = (pre == PRE_Z) || (pre == PRE_X);
    isY  = (pre == PRE_Y);
    if (isZ) begin
      nextIdx  = '0;
      nextSync = 1'b1;
    end else if (synced && (frameIdx < LAST_IDX)) begin
      nextIdx  = frameIdx + 1'b1;
      nextSync = 1'b1;
    end else begin
      nextIdx  = frameIdx;
      nextSync = 1'b0;
    end
    inWin = (nextIdx >= WIN_LO) && (nextIdx <= WIN_HI);

    ctl.strbA   = subStrobe && isA;
    ctl.strbY   = subStrobe && isY;
    ctl.capA    = subStrobe && pllLock && isA && nextSync;
    ctl.capB    = subStrobe && pllLock && isY && synced;
    ctl.refresh = ctl.capA && inWin;
    ctl.idx     = isA ? nextIdx : frameIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameIdx  <= '0;
      synced    <= 1'b0;
      blockMark <= 1'b0;
    end else if (!pllLock) begin
      synced <= 1'b0;
    end else if (subStrobe && isA) begin
      frameIdx  <= nextIdx;
      synced    <= nextSync;
      blockMark <= nextSync && inWin;
    end
  end
endmodule

// File: rtl/csi_decode.sv
module csi_decode
  import csi_pkg::*;
(
  input  logic [CS_BITS-1:0] cs,
  output logic               pro,
  output logic               nonAudio,
  output logic               copy,
  output logic               emphN,
  output logic               orig
);
  logic emph5015, invGroup;

  always_comb begin
    pro      = cs[0];
    nonAudio = cs[1];
    copy     = cs[2];
    if (cs[0])
      emph5015 = cs[2] && cs[3] && !cs[4];
    else
      emph5015 = cs[3] && !cs[4] && !cs[5];
    emphN    = !emph5015;
    invGroup = (!cs[8] && !cs[9] &&  cs[10])
            || ( cs[8] && !cs[9] && !cs[10])
            || (!cs[8] &&  cs[9] &&  cs[10] && cs[11]);
    orig     = invGroup ? !cs[15] : cs[15];
  end
endmodule

// File: rtl/csi_dp.sv
module csi_dp
  import csi_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  csi_ctl_t ctl,
  input  logic     cBit,
  input  logic     vBit,
  input  logic     parityOk,
  input  logic     bipErr,
  input  logic     pllLock,
  input  logic     chanSel,
  output logic     proOut,
  output logic     nonAudioOut,
  output logic     copyOut,
  output logic     emphN,
  output logic     origOut,
  output logic     errAll,
  output logic     errNoVal
);
  localparam logic [IDX_W-1:0] KEEP_LIM = IDX_W'(CS_BITS);

  logic               inKeep;
  logic [CS_BITS-1:0] selBits;
  logic               dPro, dNonAudio, dCopy, dEmphN, dOrig;
  logic               curErr, frameAcc;

  assign inKeep = ctl.idx < KEEP_LIM;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic               capEn;
    logic [CS_BITS-1:0] bits;
    assign capEn = (ch == 0) ? ctl.capA : ctl.capB;
    always_ff @(posedge clk) begin
      if (!rstN)
        bits <= '0;
      else if (capEn && inKeep)
        bits[ctl.idx[CS_IW-1:0]] <= cBit;
    end
  end

  assign selBits = chanSel ? g_ch[1].bits : g_ch[0].bits;

  csi_decode u_dec (
    .cs       (selBits),
    .pro      (dPro),
    .nonAudio (dNonAudio),
    .copy     (dCopy),
    .emphN    (dEmphN),
    .orig     (dOrig)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      proOut      <= 1'b0;
      nonAudioOut <= 1'b0;
      copyOut     <= 1'b0;
      emphN       <= 1'b1;
      origOut     <= 1'b0;
    end else if (ctl.refresh) begin
      proOut      <= dPro;
      nonAudioOut <= dNonAudio;
      copyOut     <= dCopy;
      emphN       <= dEmphN;
      origOut     <= dOrig;
    end
  end

  assign curErr = !parityOk || bipErr || !pllLock;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errAll   <= 1'b0;
      errNoVal <= 1'b0;
      frameAcc <= 1'b0;
    end else begin
      if (ctl.strbA || ctl.strbY) errAll <= vBit || curErr;
      if (ctl.strbA)              frameAcc <= curErr;
      if (ctl.strbY)              errNoVal <= frameAcc || curErr;
    end
  end
endmodule

// File: rtl/cs_indicator_top.sv
module cs_indicator_top
  import csi_pkg::*;
#(
  parameter int BLOCK_LEN   = 192,
  parameter int MARK_DELAY  = 2,
  parameter int MARK_FRAMES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       subStrobe,
  input  logic [1:0] preamble,
  input  logic       cBit,
  input  logic       vBit,
  input  logic       parityOk,
  input  logic       bipErr,
  input  logic       pllLock,
  input  logic       chanSel,
  output logic       blockMark,
  output logic       proOut,
  output logic       nonAudioOut,
  output logic       copyOut,
  output logic       emphN,
  output logic       origOut,
  output logic       errAll,
  output logic       errNoVal
);
  csi_ctl_t ctl;

  csi_ctrl #(
    .BLOCK_LEN   (BLOCK_LEN),
    .MARK_DELAY  (MARK_DELAY),
    .MARK_FRAMES (MARK_FRAMES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .subStrobe (subStrobe),
    .preamble  (preamble),
    .pllLock   (pllLock),
    .ctl       (ctl),
    .blockMark (blockMark)
  );

  csi_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .cBit        (cBit),
    .vBit        (vBit),
    .parityOk    (parityOk),
    .bipErr      (bipErr),
    .pllLock     (pllLock),
    .chanSel     (chanSel),
    .proOut      (proOut),
    .nonAudioOut (nonAudioOut),
    .copyOut     (copyOut),
    .emphN       (emphN),
    .origOut     (origOut),
    .errAll      (errAll),
    .errNoVal    (errNoVal)
  );
endmodule

// File: rtl/csi_chk.sv
module csi_chk (
  input logic       clk,
  input logic       rstN,
  input logic       subStrobe,
  input logic [1:0] preamble,
  input logic       vBit,
  input logic       parityOk,
  input logic       bipErr,
  input logic       pllLock,
  input logic       blockMark,
  input logic       proOut,
  input logic       nonAudioOut,
  input logic       copyOut,
  input logic       emphN,
  input logic       origOut,
  input logic       errAll,
  input logic       errNoVal
);
  logic aStrobe, yStrobe;
  assign aStrobe = subStrobe && (preamble == 2'd0 || preamble == 2'd1);
  assign yStrobe = subStrobe && (preamble == 2'd2);

  a_r2_mark_moves_on_a: assert property (@(posedge clk) disable iff (!rstN)
    !aStrobe |=> $stable(blockMark));

  a_r8_validity_sets: assert property (@(posedge clk) disable iff (!rstN)
    subStrobe && vBit |=> errAll);

  a_r8_clean_clears: assert property (@(posedge clk) disable iff (!rstN)
    subStrobe && !vBit && parityOk && !bipErr && pllLock |=> !errAll);

  a_r8_holds: assert property (@(posedge clk) disable iff (!rstN)
    !subStrobe |=> $stable(errAll));

  a_r9_only_on_y: assert property (@(posedge clk) disable iff (!rstN)
    !yStrobe |=> $stable(errNoVal));

  a_r9_bip_sets: assert property (@(posedge clk) disable iff (!rstN)
    yStrobe && bipErr |=> errNoVal);

  a_r10_hold_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    !pllLock |=> $stable({blockMark, proOut, nonAudioOut, copyOut, emphN, origOut}));
endmodule

bind cs_indicator_top csi_chk u_chk (.*);

// File: tb/tb_cs_indicator_top.sv
module tb_cs_indicator_top;
  localparam logic [1:0] PZ = 2'd0;
  localparam logic [1:0] PX = 2'd1;
  localparam logic [1:0] PY = 2'd2;

  logic clk = 1'b0;
  logic rstN, subStrobe, cBit, vBit, parityOk, bipErr, pllLock, chanSel;
  logic [1:0] preamble;
  logic blockMark, proOut, nonAudioOut, copyOut, emphN, origOut, errAll, errNoVal;

  always #5 clk = ~clk;

  cs_indicator_top dut (.*);

  int nChecks = 0;
  int nFails = 0;
  bit started = 1'b0;
  string phase = "R1 reset";

  // Reference model state
  logic [191:0] mA, mB;
  int  mIdx;
  bit  mSync, mAcc, mMark, mPro, mNa, mCopy, mEmphN, mOrig, mErrAll, mErrNoVal;

  task automatic decodeRef(input logic [191:0] s);
    bit emph, inv;
    mPro  = s[0];
    mNa   = s[1];
    mCopy = s[2];
    emph  = s[0] ? (s[2] && s[3] && !s[4]) : (s[3] && !s[4] && !s[5]);
    mEmphN = !emph;
    inv   = (s[10:8] == 3'b100) || (s[10:8] == 3'b001) || (s[11:8] == 4'b1110);
    mOrig = inv ? !s[15] : s[15];
  endtask

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rstN) begin
      mA = '0; mB = '0; mIdx = 0; mSync = 0; mAcc = 0; mMark = 0;
      mPro = 0; mNa = 0; mCopy = 0; mEmphN = 1; mOrig = 0; mErrAll = 0; mErrNoVal = 0;
    end else begin
      if (subStrobe) begin
        bit e;
        e = !parityOk || bipErr || !pllLock;
        mErrAll = vBit || e;
        if (preamble == PY) mErrNoVal = mAcc || e;
        else                mAcc = e;
      end
      if (!pllLock) mSync = 0;
      else if (subStrobe) begin
        if (preamble != PY) begin
          if (preamble == PZ) begin mIdx = 0; mSync = 1; end
          else if (mSync && mIdx < 191) mIdx = mIdx + 1;
          else mSync = 0;
          if (mSync) begin
            if (mIdx >= 2 && mIdx <= 17) begin
              decodeRef(chanSel ? mB : mA);
              mMark = 1;
            end else mMark = 0;
            mA[mIdx] = cBit;
          end else mMark = 0;
        end else if (mSync) mB[mIdx] = cBit;
      end
    end
  end

  task automatic cmp(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s [%s] at %0t: actual %b expected %b", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      cmp("R2 blockMark", blockMark, mMark);
      cmp("R4 R3 proOut", proOut, mPro);
      cmp("R4 R3 nonAudioOut", nonAudioOut, mNa);
      cmp("R4 R3 copyOut", copyOut, mCopy);
      cmp("R5 R6 emphN", emphN, mEmphN);
      cmp("R7 origOut", origOut, mOrig);
      cmp("R8 errAll", errAll, mErrAll);
      cmp("R9 errNoVal", errNoVal, mErrNoVal);
    end
  end

  task automatic sendSub(input logic [1:0] pre, input logic c, input logic v,
                         input logic par, input logic bip);
    @(negedge clk);
    subStrobe = 1'b1; preamble = pre; cBit = c; vBit = v; parityOk = par; bipErr = bip;
    @(negedge clk);
    subStrobe = 1'b0; vBit = 1'b0; parityOk = 1'b1; bipErr = 1'b0;
    @(negedge clk);
  endtask

  // errMode 1 injects validity, parity and bi-phase errors on a fixed pattern
  task automatic sendFrames(input logic [191:0] a, input logic [191:0] b,
                            input int nFr, input bit withZ, input int errMode);
    for (int f = 0; f < nFr; f++) begin
      logic [1:0] pa;
      int bi;
      bit em;
      bi = f % 192;
      em = (errMode == 1);
      pa = (withZ && f == 0) ? PZ : PX;
      sendSub(pa, a[bi], em && (f % 7 == 3), !(em && (f % 13 == 8)), em && (f == 20));
      sendSub(PY, b[bi], em && (f % 5 == 1), !(em && (f % 11 == 5)), 1'b0);
    end
  endtask

  logic [191:0] blkA1, blkB1, blkA2, blkB2;

  initial begin
    rstN = 1'b0; subStrobe = 1'b0; preamble = PX; cBit = 1'b0; vBit = 1'b0;
    parityOk = 1'b1; bipErr = 1'b0; pllLock = 1'b1; chanSel = 1'b0;
    blkA1 = '0; blkA1[2] = 1; blkA1[3] = 1; blkA1[10] = 1; blkA1[100] = 1;
    blkB1 = '0; blkB1[0] = 1; blkB1[1] = 1; blkB1[2] = 1; blkB1[3] = 1; blkB1[15] = 1;
    blkA2 = '0; blkA2[4] = 1; blkA2[8] = 1; blkA2[15] = 1; blkA2[150] = 1;
    blkB2 = '0; blkB2[0] = 1; blkB2[2] = 1; blkB2[9] = 1; blkB2[10] = 1; blkB2[11] = 1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    phase = "R3 channel A consumer";
    sendFrames(blkA1, blkB1, 192, 1'b1, 0);
    phase = "R3 channel B professional";
    chanSel = 1'b1;
    sendFrames(blkA1, blkB1, 192, 1'b1, 0);
    phase = "R9 errors channel A";
    chanSel = 1'b0;
    sendFrames(blkA2, blkB2, 192, 1'b1, 1);
    phase = "R6 channel B second set";
    chanSel = 1'b1;
    sendFrames(blkA2, blkB2, 192, 1'b1, 1);

    phase = "R10 lock loss";
    chanSel = 1'b0;
    sendFrames(blkA1, blkB1, 3, 1'b1, 0);
    pllLock = 1'b0;
    chanSel = 1'b1;
    sendFrames(blkA2, blkB2, 20, 1'b0, 0);
    repeat (10) @(negedge clk);
    pllLock = 1'b1;
    phase = "R11 no sync after relock";
    sendFrames(blkA2, blkB2, 30, 1'b0, 0);
    phase = "R11 resync at Z";
    sendFrames(blkA2, blkB2, 212, 1'b1, 0);
    phase = "R11 overrun then Z";
    chanSel = 1'b0;
    sendFrames(blkA1, blkB1, 40, 1'b1, 0);

    phase = "R1 reset again";
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog [%s]: actual timeout expected completion", phase);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule